// File: doc/BRIEF.md
# Eight-Character Display Line Buffer

This block holds one line of eight characters for a small text display and keeps the display in step with it. A bus master reads and writes the line through a request port. An access carries a byte offset and a size of 1, 2, 4 or 8 bytes. The bytes of an access run upward from the offset and wrap back to entry 0 past the last entry, so any size at any offset stays inside the eight-entry window.

Each accepted write redraws the line. The block sends a carriage-return code and then all eight characters, entry 0 first, over a byte-wide valid/ready channel. The write is applied to the buffer before the redraw starts. The block sends one blank character the first time the display sink reports that it is connected, and never sends it again.

A write that arrives while a redraw or the blank is still being sent is held off until the channel has finished. Every redraw therefore shows the line exactly as it stood after the write that caused it. Reads are never held off.

Top module: `chardisp_top`

## Requirements
- R1: After reset all eight entries hold 0x00, `out_valid` and `rsp_valid` are low, and `req_ready` is high.
- R2: `req_size` selects the access length: 0 gives 1 byte, 1 gives 2 bytes, 2 gives 4 bytes and 3 gives 8 bytes. On a write, data lane i (`req_wdata[8i+7:8i]`, so lane 0 is the least significant byte) goes to entry (`req_offset` + i) mod 8 for every i below the length. All other entries keep their values.
- R3: An access that runs past entry 7 wraps round to entry 0. For example, a 4-byte access at offset 6 covers entries 6, 7, 0 and 1.
- R4: A read is accepted in the cycle it is presented. In the next cycle `rsp_valid` is high and `rsp_rdata` lane i holds entry (`req_offset` + i) mod 8 for every i below the length, with the lanes above the length reading as zero. `rsp_valid` is low in every other cycle.
- R5: In the cycle after a write is accepted, the output carries the carriage-return code 0x0D. The eight entries follow in index order 0 to 7, one per handshake, and each shows its value after that write.
- R6: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_data` stays unchanged.
- R7: While a redraw is in progress, `req_ready` is low for writes. A write held in this way is accepted only once the last character has been taken. Reads are accepted at any time.
- R8: The first time `sink_connected` is high after reset, the block sends exactly one 0x20 beat. Dropping `sink_connected` and raising it again sends nothing.
- R9: While that blank is pending or being sent, writes are held off. The blank leaves the block before the redraw of the held write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Access request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_offset | input | 3 | Starting entry of the access |
| req_size | input | 2 | Access length code (0:1, 1:2, 2:4, 3:8 bytes) |
| req_wdata | input | 64 | Write data, lane 0 in the low byte |
| req_ready | output | 1 | Request accepted this cycle when high with req_valid |
| rsp_valid | output | 1 | Read data valid |
| rsp_rdata | output | 64 | Read data, upper lanes zero |
| sink_connected | input | 1 | Display sink reports connected |
| out_valid | output | 1 | Output byte present |
| out_data | output | 8 | Output byte |
| out_ready | input | 1 | Sink takes the byte |

## Verification
Read data is due exactly one cycle after the read is accepted. The bench presents the read at one edge and compares the response at the falling edge after the next one. The carriage return appears in the cycle after a write is accepted, and the characters follow one per handshake. A scoreboard queue takes expected beats when each write is accepted and compares them in handshake order, whatever the sink throttling, so timing jitter cannot shift a comparison. With the sink always ready, a write presented one cycle after another write is accepted must wait exactly 8 cycles. A write presented together with the first connect must wait 2 cycles, and the bench counts these stalls and compares them.

// File: rtl/chardisp_pkg.sv
package chardisp_pkg;

    localparam int CHAR_W = 8;
    localparam logic [CHAR_W-1:0] CODE_CR    = 8'h0D;
    localparam logic [CHAR_W-1:0] CODE_BLANK = 8'h20;

    // access length code: length = 1 << code
    typedef enum logic [1:0] {
        ACC_B1 = 2'd0,
        ACC_B2 = 2'd1,
        ACC_B4 = 2'd2,
        ACC_B8 = 2'd3
    } acc_size_e;

    typedef enum logic [1:0] {
        TX_IDLE  = 2'd0,
        TX_BLANK = 2'd1,
        TX_CR    = 2'd2,
        TX_CHARS = 2'd3
    } tx_state_e;

    typedef struct packed {
        logic              valid;
        logic [CHAR_W-1:0] data;
    } beat_t;

    function automatic int lanes_of(acc_size_e s);
        return 1 << s;
    endfunction

endpackage

// File: rtl/chardisp_buffer.sv
module chardisp_buffer
    import chardisp_pkg::*;
#(
    parameter int NUM_CHARS = 8,
    localparam int IDX_W  = $clog2(NUM_CHARS),
    localparam int DATA_W = NUM_CHARS * CHAR_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  offset,
    input  acc_size_e         size,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    input  logic [IDX_W-1:0]  char_idx,
    output logic [CHAR_W-1:0] char_out
);

    logic [CHAR_W-1:0] entry_q [NUM_CHARS];

    generate
        for (genvar e = 0; e < NUM_CHARS; e++) begin : g_entry
            // lane that lands on entry e for this offset (mod NUM_CHARS)
            logic [IDX_W-1:0] lane;
            assign lane = IDX_W'(e) - offset;

            always_ff @(posedge clk) begin
                if (rst) begin
                    entry_q[e] <= '0;
                end else if (wr_en && (int'(lane) < lanes_of(size))) begin
                    entry_q[e] <= wdata[int'(lane)*CHAR_W +: CHAR_W];
                end
            end
        end
    endgenerate

    always_comb begin
        rdata = '0;
        for (int i = 0; i < NUM_CHARS; i++) begin
            logic [IDX_W-1:0] src;
            src = offset + IDX_W'(i);
            if (i < lanes_of(size)) begin
                rdata[i*CHAR_W +: CHAR_W] = entry_q[src];
            end
        end
    end

    assign char_out = entry_q[char_idx];

endmodule

// File: rtl/chardisp_streamer.sv
module chardisp_streamer
    import chardisp_pkg::*;
#(
    parameter int NUM_CHARS = 8,
    localparam int IDX_W = $clog2(NUM_CHARS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_refresh,
    input  logic              sink_connected,
    input  logic              out_ready,
    input  logic [CHAR_W-1:0] char_in,
    output logic [IDX_W-1:0]  char_idx,
    output logic              busy,
    output beat_t             beat
);

    tx_state_e        state_q;
    logic [IDX_W-1:0] idx_q;
    logic             blank_done_q;
    logic             blank_pending;

    assign blank_pending = sink_connected && !blank_done_q;
    assign busy          = (state_q != TX_IDLE) || blank_pending;
    assign char_idx      = idx_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q      <= TX_IDLE;
            idx_q        <= '0;
            blank_done_q <= 1'b0;
        end else begin
            unique case (state_q)
                TX_IDLE: begin
                    if (blank_pending) begin
                        state_q      <= TX_BLANK;
                        blank_done_q <= 1'b1;
                    end else if (start_refresh) begin
                        state_q <= TX_CR;
                    end
                end
                TX_BLANK: if (out_ready) state_q <= TX_IDLE;
                TX_CR: begin
                    if (out_ready) begin
                        state_q <= TX_CHARS;
                        idx_q   <= '0;
                    end
                end
                TX_CHARS: begin
                    if (out_ready) begin
                        if (idx_q == IDX_W'(NUM_CHARS - 1)) begin
                            state_q <= TX_IDLE;
                        end
                        idx_q <= idx_q + 1'b1;
                    end
                end
                default: state_q <= TX_IDLE;
            endcase
        end
    end

    always_comb begin
        beat.valid = (state_q != TX_IDLE);
        unique case (state_q)
            TX_BLANK: beat.data = CODE_BLANK;
            TX_CR:    beat.data = CODE_CR;
            TX_CHARS: beat.data = char_in;
            default:  beat.data = '0;
        endcase
    end

endmodule

// File: rtl/chardisp_top.sv
module chardisp_top
    import chardisp_pkg::*;
#(
    parameter int NUM_CHARS = 8,
    localparam int IDX_W  = $clog2(NUM_CHARS),
    localparam int DATA_W = NUM_CHARS * CHAR_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [IDX_W-1:0]  req_offset,
    input  logic [1:0]        req_size,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              req_ready,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    input  logic              sink_connected,
    output logic              out_valid,
    output logic [CHAR_W-1:0] out_data,
    input  logic              out_ready
);

    logic              busy;
    logic              wr_acc;
    logic              rd_acc;
    logic [DATA_W-1:0] rd_lanes;
    logic [IDX_W-1:0]  char_idx;
    logic [CHAR_W-1:0] char_val;
    beat_t             beat;

    assign req_ready = !req_write || !busy;
    assign wr_acc    = req_valid && req_write && !busy;
    assign rd_acc    = req_valid && !req_write;

    chardisp_buffer #(.NUM_CHARS(NUM_CHARS)) buf_i (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_acc),
        .offset   (req_offset),
        .size     (acc_size_e'(req_size)),
        .wdata    (req_wdata),
        .rdata    (rd_lanes),
        .char_idx (char_idx),
        .char_out (char_val)
    );

    chardisp_streamer #(.NUM_CHARS(NUM_CHARS)) tx_i (
        .clk            (clk),
        .rst            (rst),
        .start_refresh  (wr_acc),
        .sink_connected (sink_connected),
        .out_ready      (out_ready),
        .char_in        (char_val),
        .char_idx       (char_idx),
        .busy           (busy),
        .beat           (beat)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            rsp_valid <= rd_acc;
            if (rd_acc) rsp_rdata <= rd_lanes;
        end
    end

    assign out_valid = beat.valid;
    assign out_data  = beat.data;

endmodule

// File: rtl/chardisp_checker.sv
module chardisp_checker (
    input logic       clk,
    input logic       rst,
    input logic       req_valid,
    input logic       req_write,
    input logic       req_ready,
    input logic       rsp_valid,
    input logic       out_valid,
    input logic       out_ready,
    input logic [7:0] out_data
);

    p_hold_r6: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

    p_cr_first_r5: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_write && req_ready) |=> (out_valid && out_data == 8'h0D));

    p_rsp_due_r4: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_write) |=> rsp_valid);

    p_rsp_quiet_r4: assert property (@(posedge clk) disable iff (rst)
        !(req_valid && !req_write) |=> !rsp_valid);

    p_stall_r7: assert property (@(posedge clk) disable iff (rst)
        (out_valid && req_write) |-> !req_ready);

    p_read_open_r7: assert property (@(posedge clk) disable iff (rst)
        !req_write |-> req_ready);

endmodule

bind chardisp_top chardisp_checker chk_i (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_write (req_write),
    .req_ready (req_ready),
    .rsp_valid (rsp_valid),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (out_data)
);

// File: tb/chardisp_top_tb_top.sv
module chardisp_top_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [2:0]  req_offset = '0;
    logic [1:0]  req_size = '0;
    logic [63:0] req_wdata = '0;
    logic        req_ready;
    logic        rsp_valid;
    logic [63:0] rsp_rdata;
    logic        sink_connected = 1'b0;
    logic        out_valid;
    logic [7:0]  out_data;
    logic        out_ready = 1'b1;

    int  n_checks = 0;
    int  n_bad = 0;
    bit  throttle = 1'b0;
    bit  finished = 1'b0;
    int  rcnt = 0;

    logic [7:0] model [8];
    logic [7:0] exp_q [$];

    always #4 clk = ~clk;

    chardisp_top dut_i (
        .clk            (clk),
        .rst            (rst),
        .req_valid      (req_valid),
        .req_write      (req_write),
        .req_offset     (req_offset),
        .req_size       (req_size),
        .req_wdata      (req_wdata),
        .req_ready      (req_ready),
        .rsp_valid      (rsp_valid),
        .rsp_rdata      (rsp_rdata),
        .sink_connected (sink_connected),
        .out_valid      (out_valid),
        .out_data       (out_data),
        .out_ready      (out_ready)
    );

    task automatic check(input bit ok, input string req, input logic [63:0] act,
                         input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    // sink throttling driver
    always @(posedge clk) begin
        #1;
        rcnt++;
        out_ready = throttle ? ((rcnt % 3) != 0) : 1'b1;
    end

    // monitor: compare each handshake against the scoreboard
    always @(negedge clk) begin
        if (!rst && out_valid && out_ready) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R5/R8 unexpected beat", {56'h0, out_data}, 64'h0);
            end else begin
                logic [7:0] e;
                e = exp_q.pop_front();
                check(out_data == e, "R5/R8 stream beat", {56'h0, out_data}, {56'h0, e});
            end
        end
    end

    function automatic logic [63:0] model_read(input int off, input int sz);
        logic [63:0] r;
        r = '0;
        for (int i = 0; i < (1 << sz); i++) r[i*8 +: 8] = model[(off + i) % 8];
        return r;
    endfunction

    task automatic do_write(input int off, input int sz, input logic [63:0] d,
                            input bit raise_conn, input int exp_stall, input string tag);
        int stalls;
        stalls = 0;
        @(posedge clk); #1;
        if (raise_conn) begin
            sink_connected = 1'b1;
            exp_q.push_back(8'h20);
        end
        req_valid  = 1'b1;
        req_write  = 1'b1;
        req_offset = 3'(off);
        req_size   = 2'(sz);
        req_wdata  = d;
        forever begin
            @(negedge clk);
            if (req_ready) break;
            stalls++;
        end
        for (int i = 0; i < (1 << sz); i++) model[(off + i) % 8] = d[i*8 +: 8];
        exp_q.push_back(8'h0D);
        for (int i = 0; i < 8; i++) exp_q.push_back(model[i]);
        @(posedge clk); #1;
        req_valid = 1'b0;
        req_write = 1'b0;
        if (exp_stall >= 0)
            check(stalls == exp_stall, tag, 64'(stalls), 64'(exp_stall));
    endtask

    task automatic do_read(input int off, input int sz, input string tag);
        logic [63:0] e;
        @(posedge clk); #1;
        req_valid  = 1'b1;
        req_write  = 1'b0;
        req_offset = 3'(off);
        req_size   = 2'(sz);
        @(negedge clk);
        check(req_ready == 1'b1, "R7 read not held off", 64'(req_ready), 64'h1);
        e = model_read(off, sz);
        @(posedge clk); #1;
        req_valid = 1'b0;
        @(negedge clk);
        check(rsp_valid == 1'b1, "R4 rsp_valid due", 64'(rsp_valid), 64'h1);
        check(rsp_rdata == e, tag, rsp_rdata, e);
    endtask

    task automatic wait_idle();
        do @(negedge clk); while (out_valid || exp_q.size() != 0);
    endtask

    initial begin
        for (int i = 0; i < 8; i++) model[i] = 8'h00;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        req_write = 1'b1;
        @(negedge clk);
        check(!out_valid, "R1 out_valid after reset", 64'(out_valid), 64'h0);
        check(!rsp_valid, "R1 rsp_valid after reset", 64'(rsp_valid), 64'h0);
        check(req_ready, "R1 req_ready after reset", 64'(req_ready), 64'h1);
        req_write = 1'b0;
        do_read(0, 3, "R1 buffer cleared");

        // byte writes, then wide writes at various offsets
        do_write(2, 0, 64'h41, 1'b0, -1, "R2");
        wait_idle();
        do_read(2, 0, "R2 single byte");
        do_read(0, 3, "R2 other entries kept");
        do_write(0, 3, 64'h4847_4645_4443_4241, 1'b0, -1, "R2");
        wait_idle();
        do_read(0, 3, "R2 eight-byte lanes");
        do_write(3, 1, 64'h7A79, 1'b0, -1, "R2");
        wait_idle();
        do_read(3, 1, "R2 two-byte at offset 3");
        do_read(1, 2, "R4 four-byte read mid window");

        // wrap-around
        do_write(6, 2, 64'h3433_3231, 1'b0, -1, "R3");
        wait_idle();
        do_read(0, 3, "R3 wrap write landed in 6,7,0,1");
        do_read(7, 1, "R3 wrap two-byte read");
        do_read(5, 3, "R3 wrap eight-byte read");
        do_write(7, 3, 64'h6867_6665_6463_6261, 1'b0, -1, "R3");
        wait_idle();
        do_read(0, 3, "R3 eight-byte write at offset 7");

        // back-to-back writes: second held off for the whole stream
        do_write(4, 0, 64'h55, 1'b0, -1, "R7");
        do_write(5, 0, 64'h56, 1'b0, 8, "R7 stall length of held write");
        // read during stream still served
        do_read(4, 1, "R7 read during stream");
        wait_idle();

        // throttled sink: stream holds under backpressure
        throttle = 1'b1;
        do_write(1, 2, 64'hA1B2_C3D4, 1'b0, -1, "R6");
        do_write(0, 0, 64'h30, 1'b0, -1, "R6");
        wait_idle();
        throttle = 1'b0;
        do_read(0, 3, "R6 buffer after throttled writes");

        // first connect together with a write
        do_write(2, 0, 64'h21, 1'b1, 2, "R9 write held off behind blank");
        wait_idle();
        // reconnect: no second blank
        @(posedge clk); #1 sink_connected = 1'b0;
        repeat (4) @(posedge clk);
        #1 sink_connected = 1'b1;
        for (int i = 0; i < 12; i++) begin
            @(negedge clk);
            check(!out_valid, "R8 no second blank", 64'(out_valid), 64'h0);
        end
        check(exp_q.size() == 0, "R5 scoreboard drained", 64'(exp_q.size()), 64'h0);

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", n_checks, n_bad);
        $finish;
    end

    initial begin
        #(8 * 100000);
        if (!finished) begin
            n_checks++;
            n_bad++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("test done: total=%0d bad=%0d", n_checks, n_bad);
            $finish;
        end
    end

endmodule